// File: doc/BRIEF.md
# Lane Alignment Group Controller

This controller sits between eight receive deskew channels and the read side of their elastic buffers. Each channel raises a ready flag once it has stored its first framing word. The controller gathers these flags into alignment groups. When every enabled lane of a group is ready and a programmable margin has elapsed, it releases one shared read-start pulse to all of them. If the group does not fill within a fixed window, it raises a sync error instead.

The lanes are split into two quads of four (lanes 0 to 3 form quad 0, lanes 4 to 7 form quad 1). Each quad can run its lanes alone, as two pairs, or as one group of four, and a global setting joins all eight lanes. A disabled lane is left out of its group's condition. When a lane is enabled again, or when a per-lane resync request arrives, the whole group returns to idle and aligns afresh.

Top module: `lane_align_ctrl`

## Requirements
- R1: While reset is asserted, and after it until a group qualifies, lane_start and sync_err are all zero, whatever lane_ready shows.
- R2: Grouping inside quad q uses quad_mode[2q+1:2q]: 2'b00 makes every lane its own group, 2'b01 makes pairs of lanes {0,1} and {2,3} of that quad, 2'b10 or 2'b11 makes the four lanes of the quad one group; lanes 0-3 are quad 0 and lanes 4-7 are quad 1.
- R3: When all_lanes is 1, all eight lanes form one group, whatever quad_mode holds.
- R4: A group pulses lane_start only when every enabled member has lane_ready high, and the pulse appears in the same cycle on every enabled member.
- R5: If the edge at which all enabled members are first seen ready is edge L, lane_start is high for exactly the one cycle after edge L+1+margin_cfg.
- R6: If a group's enabled members are not all seen ready within WINDOW (24) edges after the edge at which its first member is seen ready, sync_err rises on every enabled member and stays high until that group is resynchronized.
- R7: A disabled lane (lane_en low) does not hold back its group, including when it is dropped while the group is waiting, and it receives neither lane_start nor sync_err.
- R8: A 0-to-1 change of lane_en on any lane returns that lane's whole group to idle, clearing its error and allowing a new pulse.
- R9: resync_req high on any member lane at a clock edge returns the group to idle from any state; with its lanes still ready, the group then pulses again.
- R10: After its pulse a group issues no further lane_start until it is resynchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_en | input | 8 | Per-lane enable; a low lane is left out of its group |
| lane_ready | input | 8 | Per-lane flag: first framing word has been stored |
| resync_req | input | 8 | Per-lane request to restart the alignment of its group |
| quad_mode | input | 4 | Grouping code per quad, two bits each, quad 0 in the low bits |
| all_lanes | input | 1 | Join all eight lanes into a single group |
| margin_cfg | input | 4 | Extra cycles to wait after the group is complete |
| lane_start | output | 8 | One-cycle shared read-start pulse per lane |
| sync_err | output | 8 | Per-lane alignment failure, held until resync |

## Verification
The hardest case to reach from the ports is the exact edge of the skew window. There, the last lane of a group becomes ready on the final edge that is still accepted, or on one edge later. The bench raises the first lane, then counts falling edges before raising its partner. Each setting is run from a fresh reset, so the two outcomes are one cycle apart and cannot be confused. A second hard case is a group that is already running when a lane comes back. The bench reaches it by dropping the ready flags, re-enabling the lane and raising the flags again, then checks for a second pulse.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [2:0] {
    GS_IDLE   = 3'd0,
    GS_WAIT   = 3'd1,
    GS_MARGIN = 3'd2,
    GS_RUN    = 3'd3,
    GS_ERROR  = 3'd4
  } grp_state_e;

  // Index of the lane that leads the group a lane belongs to.
  function automatic int group_leader(input int lane, input int lanes_per_quad,
                                      input logic [1:0] qmode, input logic join_all);
    int base;
    base = (lane / lanes_per_quad) * lanes_per_quad;
    if (join_all) return 0;
    if (qmode[1]) return base;
    if (qmode[0]) return lane - (lane % 2);
    return lane;
  endfunction

  // True when every member lane is either disabled or ready.
  function automatic logic members_complete(input logic [31:0] member, input logic [31:0] en,
                                            input logic [31:0] rdy);
    return &(~member | ~en | rdy);
  endfunction

endpackage

// File: rtl/lane_group_map.sv
module lane_group_map
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES      = 8,
  parameter int LANES_PER_QUAD = 4,
  parameter int NUM_QUADS      = NUM_LANES / LANES_PER_QUAD
) (
  input  logic [2*NUM_QUADS-1:0] quad_mode,
  input  logic                   all_lanes,
  input  logic [NUM_LANES-1:0]   lane_en,
  input  logic [NUM_LANES-1:0]   lane_ready,
  input  logic [NUM_LANES-1:0]   lane_kick,
  output logic [NUM_LANES-1:0]   lane_sel [NUM_LANES],
  output logic [NUM_LANES-1:0]   slot_active,
  output logic [NUM_LANES-1:0]   slot_any_rdy,
  output logic [NUM_LANES-1:0]   slot_all_rdy,
  output logic [NUM_LANES-1:0]   slot_resync
);

  logic [NUM_LANES-1:0] member [NUM_LANES];

  // one-hot slot selection per lane
  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    localparam int QIDX = j / LANES_PER_QUAD;
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_slot
      assign lane_sel[j][i] =
        (group_leader(j, LANES_PER_QUAD, quad_mode[2*QIDX +: 2], all_lanes) == i);
      assign member[i][j] = lane_sel[j][i];
    end
  end

  // per-slot group conditions
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_cond
    logic [31:0] m32, e32, r32;
    assign m32 = 32'(member[i]);
    assign e32 = 32'(lane_en);
    assign r32 = 32'(lane_ready);
    assign slot_active[i]  = |(member[i] & lane_en);
    assign slot_any_rdy[i] = |(member[i] & lane_en & lane_ready);
    assign slot_all_rdy[i] = members_complete(m32, e32, r32);
    assign slot_resync[i]  = |(member[i] & lane_kick);
  end

endmodule

// File: rtl/align_group_fsm.sv
module align_group_fsm
  import lane_align_pkg::*;
#(
  parameter int WINDOW   = 24,
  parameter int MARGIN_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                any_rdy,
  input  logic                all_rdy,
  input  logic                resync,
  input  logic [MARGIN_W-1:0] margin_cfg,
  output logic                start,
  output logic                err,
  output logic                idle,
  output logic                in_margin
);

  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  grp_state_e          state;
  logic [WIN_W-1:0]    wcnt;
  logic [MARGIN_W-1:0] mcnt;
  logic                start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= GS_IDLE;
      wcnt    <= '0;
      mcnt    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (resync) begin
        state <= GS_IDLE;
        wcnt  <= '0;
        mcnt  <= '0;
      end else begin
        case (state)
          GS_IDLE: begin
            if (active && any_rdy) begin
              wcnt  <= '0;
              mcnt  <= '0;
              state <= all_rdy ? GS_MARGIN : GS_WAIT;
            end
          end
          GS_WAIT: begin
            if (!active)               state <= GS_IDLE;
            else if (all_rdy)          begin state <= GS_MARGIN; mcnt <= '0; end
            else if (wcnt == WIN_LAST) state <= GS_ERROR;
            else                       wcnt  <= wcnt + WIN_W'(1);
          end
          GS_MARGIN: begin
            if (mcnt == margin_cfg) begin
              state   <= GS_RUN;
              start_q <= 1'b1;
            end else begin
              mcnt <= mcnt + MARGIN_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign start     = start_q;
  assign err       = (state == GS_ERROR);
  assign idle      = (state == GS_IDLE);
  assign in_margin = (state == GS_MARGIN);

endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl #(
  parameter int NUM_LANES      = 8,
  parameter int LANES_PER_QUAD = 4,
  parameter int WINDOW         = 24,
  parameter int MARGIN_W       = 4,
  parameter int NUM_QUADS      = NUM_LANES / LANES_PER_QUAD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LANES-1:0]   lane_en,
  input  logic [NUM_LANES-1:0]   lane_ready,
  input  logic [NUM_LANES-1:0]   resync_req,
  input  logic [2*NUM_QUADS-1:0] quad_mode,
  input  logic                   all_lanes,
  input  logic [MARGIN_W-1:0]    margin_cfg,
  output logic [NUM_LANES-1:0]   lane_start,
  output logic [NUM_LANES-1:0]   sync_err
);

  logic [NUM_LANES-1:0] en_q, en_rise, lane_kick;
  logic [NUM_LANES-1:0] lane_sel [NUM_LANES];
  logic [NUM_LANES-1:0] slot_active, slot_any_rdy, slot_all_rdy;
  logic [NUM_LANES-1:0] grp_resync, grp_start, grp_err, grp_idle, grp_margin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= lane_en;
  end

  assign en_rise   = lane_en & ~en_q;
  assign lane_kick = resync_req | en_rise;

  lane_group_map #(
    .NUM_LANES(NUM_LANES), .LANES_PER_QUAD(LANES_PER_QUAD), .NUM_QUADS(NUM_QUADS)
  ) u_map (
    .quad_mode   (quad_mode),
    .all_lanes   (all_lanes),
    .lane_en     (lane_en),
    .lane_ready  (lane_ready),
    .lane_kick   (lane_kick),
    .lane_sel    (lane_sel),
    .slot_active (slot_active),
    .slot_any_rdy(slot_any_rdy),
    .slot_all_rdy(slot_all_rdy),
    .slot_resync (grp_resync)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_grp
    align_group_fsm #(.WINDOW(WINDOW), .MARGIN_W(MARGIN_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (slot_active[i]),
      .any_rdy   (slot_any_rdy[i]),
      .all_rdy   (slot_all_rdy[i]),
      .resync    (grp_resync[i]),
      .margin_cfg(margin_cfg),
      .start     (grp_start[i]),
      .err       (grp_err[i]),
      .idle      (grp_idle[i]),
      .in_margin (grp_margin[i])
    );
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_out
    assign lane_start[j] = lane_en[j] & |(grp_start & lane_sel[j]);
    assign sync_err[j]   = lane_en[j] & |(grp_err & lane_sel[j]);
  end

endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
  parameter int NUM_LANES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LANES-1:0] lane_en,
  input logic [NUM_LANES-1:0] lane_start,
  input logic [NUM_LANES-1:0] sync_err,
  input logic [NUM_LANES-1:0] grp_start,
  input logic [NUM_LANES-1:0] grp_err,
  input logic [NUM_LANES-1:0] grp_resync,
  input logic [NUM_LANES-1:0] grp_idle,
  input logic [NUM_LANES-1:0] grp_margin
);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_start & $past(lane_start)) == '0);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_slot
    // R5
    start_after_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_start[i] |-> $past(grp_margin[i]));
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grp_err[i]) && !$past(grp_resync[i])) |-> grp_err[i]);
    // R9
    resync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_resync[i] |=> grp_idle[i]);
    // R4
    start_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(grp_start[i] && grp_err[i]));
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    // R8
    reenable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[j] && !$past(lane_en[j])) |=> !sync_err[j]);
  end

endmodule

bind lane_align_ctrl lane_align_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_en   (lane_en),
  .lane_start(lane_start),
  .sync_err  (sync_err),
  .grp_start (grp_start),
  .grp_err   (grp_err),
  .grp_resync(grp_resync),
  .grp_idle  (grp_idle),
  .grp_margin(grp_margin)
);

// File: tb/tb_lane_align_ctrl.sv
module tb_lane_align_ctrl;

  localparam int WIN = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lane_en = 8'hFF, lane_ready = 8'h00, resync_req = 8'h00;
  logic [3:0] quad_mode = 4'h0;
  logic       all_lanes = 1'b0;
  logic [3:0] margin_cfg = 4'd2;
  logic [7:0] lane_start, sync_err;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] seen;
  int pcnt [8];

  always #4 clk = ~clk;

  lane_align_ctrl dut (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .lane_ready(lane_ready),
    .resync_req(resync_req), .quad_mode(quad_mode), .all_lanes(all_lanes),
    .margin_cfg(margin_cfg), .lane_start(lane_start), .sync_err(sync_err)
  );

  typedef struct packed {
    logic       all;
    logic [3:0] qm;
    logic [7:0] en;
    logic [7:0] rdy;
    logic [7:0] st;
    logic [7:0] er;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 4'b0000, 8'hFF, 8'h05, 8'h05, 8'h00},  // R2 independent
    '{1'b0, 4'b0101, 8'hFF, 8'h0F, 8'h0F, 8'h00},  // R2 pairs complete
    '{1'b0, 4'b0101, 8'hFF, 8'h01, 8'h00, 8'h03},  // R2 pair short
    '{1'b0, 4'b0010, 8'hFF, 8'h0F, 8'h0F, 8'h00},  // R2 quad complete
    '{1'b0, 4'b0010, 8'hFF, 8'h07, 8'h00, 8'h0F},  // R2 quad short
    '{1'b1, 4'b0000, 8'hFF, 8'hFF, 8'hFF, 8'h00},  // R3 all eight
    '{1'b1, 4'b0000, 8'hFF, 8'h7F, 8'h00, 8'hFF},  // R3 all eight short
    '{1'b1, 4'b0000, 8'h7F, 8'h7F, 8'h7F, 8'h00},  // R7 lane 7 off
    '{1'b0, 4'b1001, 8'hEF, 8'hE3, 8'hE3, 8'h00},  // R7 lane 4 off, mixed
    '{1'b1, 4'b0101, 8'hFF, 8'h03, 8'h00, 8'hFF}   // R3 overrides pairs
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    seen = 8'h00;
    for (int l = 0; l < 8; l++) pcnt[l] = 0;
  endtask

  task automatic observe(input int n);
    repeat (n) begin
      @(negedge clk);
      seen |= lane_start;
      for (int l = 0; l < 8; l++) if (lane_start[l]) pcnt[l]++;
    end
  endtask

  function automatic int max_pulses();
    int m = 0;
    for (int l = 0; l < 8; l++) if (pcnt[l] > m) m = pcnt[l];
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lane_ready = 8'h00; resync_req = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic margin_run(input int m);
    int first = -1;
    int cnt = 0;
    margin_cfg = 4'(m); all_lanes = 1'b0; quad_mode = 4'h0; lane_en = 8'hFF;
    do_reset();
    lane_ready = 8'h01;
    for (int n = 1; n <= m + 6; n++) begin
      @(negedge clk);
      if (lane_start[0]) begin
        cnt++;
        if (first < 0) first = n;
      end
    end
    chk("R5 pulse position", first, m + 2);
    chk("R5 pulse width", cnt, 1);
  endtask

  task automatic window_run(input int lag, input logic ok);
    margin_cfg = 4'd0; all_lanes = 1'b0; quad_mode = 4'b0001; lane_en = 8'hFF;
    do_reset();
    clear_obs();
    lane_ready = 8'h01;
    repeat (lag) @(negedge clk);
    lane_ready = 8'h03;
    observe(40);
    chk("R6 window start", seen, ok ? 8'h03 : 8'h00);
    chk("R6 window error", sync_err, ok ? 8'h00 : 8'h03);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    // R1 reset state with ready flags high
    rst_n = 1'b0; lane_ready = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", lane_start, 8'h00);
    chk("R1 err in reset", sync_err, 8'h00);
    lane_ready = 8'h00;
    rst_n = 1'b1;
    clear_obs();
    observe(5);
    chk("R1 start after reset", seen, 8'h00);
    chk("R1 err after reset", sync_err, 8'h00);

    // table of grouping cases
    for (int v = 0; v < 10; v++) begin
      all_lanes = VECS[v].all; quad_mode = VECS[v].qm; lane_en = VECS[v].en;
      margin_cfg = 4'd2;
      do_reset();
      clear_obs();
      lane_ready = VECS[v].rdy;
      observe(40);
      chk($sformatf("R2/R3/R4/R7 vec%0d start", v), seen, VECS[v].st);
      chk($sformatf("R6 vec%0d err", v), sync_err, VECS[v].er);
      chk($sformatf("R10 vec%0d pulses", v), max_pulses(), (VECS[v].st != 0) ? 1 : 0);
    end

    // R5 margin timing
    margin_run(3);
    margin_run(0);

    // R6 window edge
    window_run(WIN, 1'b1);
    window_run(WIN + 1, 1'b0);

    // R7 lane dropped while waiting
    margin_cfg = 4'd1; all_lanes = 1'b0; quad_mode = 4'b0001; lane_en = 8'hFF;
    do_reset();
    clear_obs();
    lane_ready = 8'h01;
    repeat (3) @(negedge clk);
    lane_en = 8'hFD;
    observe(40);
    chk("R7 dropped lane start", seen, 8'h01);
    chk("R7 dropped lane err", sync_err, 8'h00);

    // R8 lane re-enabled after group ran
    margin_cfg = 4'd2; all_lanes = 1'b1; quad_mode = 4'h0; lane_en = 8'h7F;
    do_reset();
    clear_obs();
    lane_ready = 8'h7F;
    observe(10);
    chk("R8 first run", seen, 8'h7F);
    lane_ready = 8'h00;
    repeat (3) @(negedge clk);
    lane_en = 8'hFF;
    repeat (3) @(negedge clk);
    clear_obs();
    lane_ready = 8'hFF;
    observe(12);
    chk("R8 rerun after enable", seen, 8'hFF);

    // R10 no repeat while running, R9 resync from running
    clear_obs();
    observe(20);
    chk("R10 no second pulse", seen, 8'h00);
    resync_req = 8'h01;
    @(negedge clk);
    resync_req = 8'h00;
    clear_obs();
    observe(12);
    chk("R9 resync from run", seen, 8'hFF);
    chk("R9 single pulse", max_pulses(), 1);

    // R6 sticky error, R9 resync from error
    all_lanes = 1'b0; quad_mode = 4'b0001; lane_en = 8'hFF;
    do_reset();
    lane_ready = 8'h01;
    observe(30);
    chk("R6 error raised", sync_err, 8'h03);
    observe(10);
    chk("R6 error held", sync_err, 8'h03);
    lane_ready = 8'h00;
    resync_req = 8'h02;
    @(negedge clk);
    resync_req = 8'h00;
    clear_obs();
    observe(2);
    chk("R9 error cleared", sync_err, 8'h00);
    chk("R9 no pulse on clear", seen, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule